// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a bank of 32-bit control and status registers on a plain word bus. The bus has a byte address, a write strobe, write data and combinational read data. It holds the following:

- an LED register and a switch readback;
- up to five oscillator setting words, each paired with a writable shadow word;
- a key-protected lock register;
- a volatile and a nonvolatile flag word, each with set and clear aliases;
- a reset-control word;
- two free-running counters.

Software unlocks the bank by writing a key word. While the bank is locked, the oscillator words, their shadows and the reset-control word ignore writes.

Three reset inputs act at different depths:

- **Power-on** (`por_n` low) returns everything to its default.
- **Reconfigure** (`reconfig` pulse) copies every shadow oscillator word into its live word. This lets trial clock settings be applied without a power cycle.
- **Programmable soft reset** (`soft_rst`) clears only the volatile group: LEDs, the lock register, the volatile flags and the fast counter.

Top module: `sysctl_regbank`

## Requirements
- R1: While `por_n` is low at a rising edge, every register takes its default value. These defaults are: LED 0, lock register locked with low half 0, both flag words 0, reset-control 0, both counters 0. Live and shadow oscillator word i both become OSC_BASE+i.
- R2: A write of exactly 0x0000A05F to offset 0x20 unlocks the bank, and a write of any other value relocks it. A read of 0x20 returns the last written bits [15:0], with bit 16 = 1 while the bank is locked and the remaining bits 0.
- R3: Oscillator words (offset 0x0C+4i), shadow words (0x8C+4i) and reset-control (0x40) take a write only while unlocked. While locked, such writes leave the stored value unchanged.
- R4: A write to 0x30 sets the volatile flag bits that are 1 in the data, and a write to 0x34 clears them. A read of 0x30 returns the flags.
- R5: The nonvolatile flags use the same scheme at 0x38 (set and read) and 0x3C (clear), and only power-on clears them.
- R6: A `reconfig` pulse loads each live oscillator word from its shadow at the next edge and leaves the shadows unchanged. Reconfigure wins over a same-cycle live write.
- R7: A `soft_rst` pulse sets the following to their defaults: LED, lock register (relocked), volatile flags and the fast counter. Oscillator and shadow words, reset-control, nonvolatile flags and the slow counter keep their values.
- R8: The read-only counter at 0x24 increments once every TICK_DIV clock cycles and wraps at 32 bits.
- R9: The read-only counter at 0x5C increments on every clock cycle and wraps at 32 bits.
- R10: The following reads and outputs apply:
  - Offset 0x04 reads `sw_in` in bits [7:0].
  - Offset 0x08 is read/write in bits [7:0], and those bits drive `led_out`.
  - Upper bits of both read 0.
  - Oscillator words drive `osc_out`, word i at bits [32i+31:32i].
  - Reset-control drives `rst_ctl_out`.
- R11: Reads return 0 at unmapped offsets, at misaligned addresses (bits [1:0] not 00) and at the clear aliases 0x34/0x3C. Writes to read-only or unmapped offsets, and writes at misaligned addresses, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| reconfig | input | 1 | Reload live oscillator words from shadows |
| soft_rst | input | 1 | Programmable soft reset, active high |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| sw_in | input | 8 | Switch inputs |
| led_out | output | 8 | LED drive |
| osc_out | output | NOSC*32 | Live oscillator setting words |
| rst_ctl_out | output | 32 | Reset-control word |

## Verification
Directed sequences exercise the following, each at a point where the outcome tells a correct bank apart from a plausible wrong one:

- locked versus unlocked writes;
- the exact key against near-miss values;
- set and clear aliases with overlapping bit masks;
- reconfigure with shadows that differ from the live words;
- a soft reset after the nonvolatile flags hold data.

The counters are read a known number of cycles apart. This separates per-clock counting, prescaled counting and the reset group each counter belongs to. A seeded random mix of writes, reads, misaligned addresses, reconfigure and soft reset pulses is then compared with a bench model. This catches interactions between lock state and reset depth that the directed cases do not combine.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int DW = 32;
   localparam logic [7:0] OFS_SW     = 8'h04;
   localparam logic [7:0] OFS_LED    = 8'h08;
   localparam logic [7:0] OFS_OSC0   = 8'h0C;
   localparam logic [7:0] OFS_LOCK   = 8'h20;
   localparam logic [7:0] OFS_SLOW   = 8'h24;
   localparam logic [7:0] OFS_FLG    = 8'h30;
   localparam logic [7:0] OFS_FLGCLR = 8'h34;
   localparam logic [7:0] OFS_NV     = 8'h38;
   localparam logic [7:0] OFS_NVCLR  = 8'h3C;
   localparam logic [7:0] OFS_RCTL   = 8'h40;
   localparam logic [7:0] OFS_FAST   = 8'h5C;
   localparam logic [7:0] OFS_SHD0   = 8'h8C;
   localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_A05F;
   localparam int LOCK_FLAG_BIT = 16;
endpackage

// File: rtl/sysctl_ticker.sv
module sysctl_ticker #(
   parameter int TICK_DIV = 240000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("sysctl_ticker: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_pass
      assign tick = rst_n;
   end else begin : g_div
      logic [CW-1:0] cnt_q;
      assign tick = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
         if (!rst_n)    cnt_q <= '0;
         else if (tick) cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;
      end

      // One tick per period: a tick is never followed by another tick
      assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/sysctl_flagreg.sv
module sysctl_flagreg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sysctl_flagreg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q | (set_en ? din : '0)) & ~(clr_en ? din : '0);
   end

   assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ((q & $past(din)) == $past(din)));
   assert_flag_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(din)) == '0));
endmodule

// File: rtl/sysctl_oscbank.sv
module sysctl_oscbank #(
   parameter int          NOSC     = 5,
   parameter logic [31:0] OSC_BASE = 32'h0002_C77C
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               reconfig,
   input  logic [NOSC-1:0]    wr_live,
   input  logic [NOSC-1:0]    wr_shadow,
   input  logic [31:0]        wdata,
   output logic [NOSC*32-1:0] live,
   output logic [NOSC*32-1:0] shadow
);
   for (genvar i = 0; i < NOSC; i++) begin : g_osc
      localparam logic [31:0] DEF = OSC_BASE + 32'(i);
      logic [31:0] live_q, shd_q;
      always_ff @(posedge clk) begin
         if (!por_n) begin
            live_q <= DEF;
            shd_q  <= DEF;
         end else begin
            if (reconfig)        live_q <= shd_q;
            else if (wr_live[i]) live_q <= wdata;
            if (wr_shadow[i])    shd_q  <= wdata;
         end
      end
      assign live[i*32 +: 32]   = live_q;
      assign shadow[i*32 +: 32] = shd_q;
   end

   assert_reload_R6: assert property (@(posedge clk) disable iff (!por_n)
      reconfig |=> (live == $past(shadow)));
   assert_shadow_kept_R6: assert property (@(posedge clk) disable iff (!por_n)
      (wr_shadow == '0) |=> $stable(shadow));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
   parameter int          ADDR_W   = 8,
   parameter int          NOSC     = 5,
   parameter logic [31:0] OSC_BASE = 32'h0002_C77C,
   parameter int          TICK_DIV = 240000
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               reconfig,
   input  logic               soft_rst,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic [7:0]         sw_in,
   output logic [7:0]         led_out,
   output logic [NOSC*32-1:0] osc_out,
   output logic [31:0]        rst_ctl_out
);
   import sysctl_pkg::*;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("sysctl_regbank: ADDR_W must be at least 8");
   end
   if (NOSC < 1 || NOSC > 5) begin : g_bad_nosc
      $error("sysctl_regbank: NOSC must be 1..5");
   end

   logic       hit, we_ok, lvl6_n, locked, unlocked;
   logic [7:0] ofs;
   assign hit      = (addr[1:0] == 2'b00) && ((addr >> 8) == '0);
   assign ofs      = addr[7:0];
   assign we_ok    = wr_en && hit;
   assign lvl6_n   = por_n && !soft_rst;
   assign unlocked = !locked;

   // lock register (level 6, never itself lockable)
   logic [15:0] lock_low_q;
   always_ff @(posedge clk) begin
      if (!lvl6_n) begin
         lock_low_q <= '0;
         locked     <= 1'b1;
      end else if (we_ok && ofs == OFS_LOCK) begin
         lock_low_q <= wr_data[15:0];
         locked     <= (wr_data != UNLOCK_KEY);
      end
   end

   // LED (level 6)
   always_ff @(posedge clk) begin
      if (!lvl6_n)                     led_out <= '0;
      else if (we_ok && ofs == OFS_LED) led_out <= wr_data[7:0];
   end

   // reset control (level 0, lockable)
   always_ff @(posedge clk) begin
      if (!por_n)                                   rst_ctl_out <= '0;
      else if (we_ok && unlocked && ofs == OFS_RCTL) rst_ctl_out <= wr_data;
   end

   // counters: fast is level 6, slow is level 0
   logic [31:0] fast_q, slow_q;
   logic        tick;
   always_ff @(posedge clk) begin
      if (!lvl6_n) fast_q <= '0;
      else         fast_q <= fast_q + 1'b1;
   end
   always_ff @(posedge clk) begin
      if (!por_n)    slow_q <= '0;
      else if (tick) slow_q <= slow_q + 1'b1;
   end

   sysctl_ticker #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(por_n), .tick(tick));

   // flag words
   logic [31:0] vflags, nvflags;
   sysctl_flagreg #(.W(32)) u_vflags (
      .clk(clk), .rst_n(lvl6_n),
      .set_en(we_ok && ofs == OFS_FLG), .clr_en(we_ok && ofs == OFS_FLGCLR),
      .din(wr_data), .q(vflags));
   sysctl_flagreg #(.W(32)) u_nvflags (
      .clk(clk), .rst_n(por_n),
      .set_en(we_ok && ofs == OFS_NV), .clr_en(we_ok && ofs == OFS_NVCLR),
      .din(wr_data), .q(nvflags));

   // oscillator words and shadows (live level 2, shadows level 0)
   logic [NOSC-1:0]    wr_live, wr_shd;
   logic [NOSC*32-1:0] shd_words;
   for (genvar i = 0; i < NOSC; i++) begin : g_osc_dec
      assign wr_live[i] = we_ok && unlocked && (ofs == OFS_OSC0 + 8'(4*i));
      assign wr_shd[i]  = we_ok && unlocked && (ofs == OFS_SHD0 + 8'(4*i));
   end

   sysctl_oscbank #(.NOSC(NOSC), .OSC_BASE(OSC_BASE)) u_osc (
      .clk(clk), .por_n(por_n), .reconfig(reconfig),
      .wr_live(wr_live), .wr_shadow(wr_shd), .wdata(wr_data),
      .live(osc_out), .shadow(shd_words));

   // read multiplexer
   always_comb begin
      rd_data = '0;
      if (hit) begin
         case (ofs)
            OFS_SW:   rd_data = {24'b0, sw_in};
            OFS_LED:  rd_data = {24'b0, led_out};
            OFS_LOCK: rd_data = {15'b0, locked, lock_low_q};
            OFS_SLOW: rd_data = slow_q;
            OFS_FLG:  rd_data = vflags;
            OFS_NV:   rd_data = nvflags;
            OFS_RCTL: rd_data = rst_ctl_out;
            OFS_FAST: rd_data = fast_q;
            default:  rd_data = '0;
         endcase
         for (int i = 0; i < NOSC; i++) begin
            if (ofs == OFS_OSC0 + 8'(4*i)) rd_data = osc_out[i*32 +: 32];
            if (ofs == OFS_SHD0 + 8'(4*i)) rd_data = shd_words[i*32 +: 32];
         end
      end
   end

   // assertions
   assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!por_n)
      (we_ok && ofs == OFS_LOCK && wr_data == UNLOCK_KEY && !soft_rst) |=> !locked);
   assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
      (locked && !reconfig) |=> ($stable(osc_out) && $stable(rst_ctl_out)));
   assert_soft_led_R7: assert property (@(posedge clk) disable iff (!por_n)
      soft_rst |=> (led_out == '0 && fast_q == '0));
   assert_fast_step_R9: assert property (@(posedge clk) disable iff (!por_n)
      !soft_rst |=> (fast_q == $past(fast_q) + 32'd1));
   assert_slow_step_R8: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> (slow_q - $past(slow_q)) <= 32'd1);
endmodule

// File: tb/sysctl_regbank_test.sv
`timescale 1ns/1ps
module sysctl_regbank_test;
   localparam int          NOSC = 5;
   localparam logic [31:0] BASE = 32'h0002_C77C;
   localparam int          DIV  = 10;
   localparam logic [31:0] KEY  = 32'h0000_A05F;

   logic clk = 1'b0;
   logic por_n = 1'b0, reconfig = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [7:0]  sw_in = 8'h5A, led_out;
   logic [NOSC*32-1:0] osc_out;
   logic [31:0] rst_ctl_out;

   always #4 clk = ~clk;

   sysctl_regbank #(.ADDR_W(8), .NOSC(NOSC), .OSC_BASE(BASE), .TICK_DIV(DIV)) uut (
      .clk(clk), .por_n(por_n), .reconfig(reconfig), .soft_rst(soft_rst),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .sw_in(sw_in), .led_out(led_out), .osc_out(osc_out), .rst_ctl_out(rst_ctl_out));

   int total = 0, bad = 0;

   // bench model
   logic [7:0]  m_led;
   logic [15:0] m_lock_low;
   logic        m_locked;
   logic [31:0] m_fl, m_nv, m_rctl;
   logic [31:0] m_osc [NOSC];
   logic [31:0] m_shd [NOSC];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_por();
      m_led = '0; m_lock_low = '0; m_locked = 1'b1;
      m_fl = '0; m_nv = '0; m_rctl = '0;
      for (int i = 0; i < NOSC; i++) begin
         m_osc[i] = BASE + 32'(i);
         m_shd[i] = BASE + 32'(i);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] r = '0;
      if (a[1:0] != 2'b00) return '0;
      case (a)
         8'h04: r = {24'b0, sw_in};
         8'h08: r = {24'b0, m_led};
         8'h20: r = {15'b0, m_locked, m_lock_low};
         8'h30: r = m_fl;
         8'h38: r = m_nv;
         8'h40: r = m_rctl;
         default: r = '0;
      endcase
      for (int i = 0; i < NOSC; i++) begin
         if (a == 8'h0C + 8'(4*i)) r = m_osc[i];
         if (a == 8'h8C + 8'(4*i)) r = m_shd[i];
      end
      return r;
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a[1:0] != 2'b00)                 return "R11 misaligned";
      if (a == 8'h20)                      return "R2 lock";
      if (a == 8'h30)                      return "R4 flags";
      if (a == 8'h38)                      return "R5 nvflags";
      if (a == 8'h04 || a == 8'h08)        return "R10 sw/led";
      if (a == 8'h40)                      return "R3 rctl";
      if (a >= 8'h0C && a <= 8'h1C)        return "R6 osc";
      if (a >= 8'h8C && a <= 8'h9C)        return "R3 shadow";
      return "R11 unmapped";
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      logic ul = !m_locked;
      if (a[1:0] != 2'b00) return;
      case (a)
         8'h08: m_led = d[7:0];
         8'h20: begin m_lock_low = d[15:0]; m_locked = (d != KEY); end
         8'h30: m_fl = m_fl | d;
         8'h34: m_fl = m_fl & ~d;
         8'h38: m_nv = m_nv | d;
         8'h3C: m_nv = m_nv & ~d;
         8'h40: if (ul) m_rctl = d;
         default: ;
      endcase
      for (int i = 0; i < NOSC; i++) begin
         if (ul && a == 8'h0C + 8'(4*i)) m_osc[i] = d;
         if (ul && a == 8'h8C + 8'(4*i)) m_shd[i] = d;
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      addr = a; #1;
      chk(tag, rd_data, exp_read(a));
   endtask

   task automatic rd_val(input logic [7:0] a, output logic [31:0] v);
      addr = a; #1; v = rd_data;
   endtask

   task automatic pulse_reconfig();
      reconfig = 1'b1; @(negedge clk); reconfig = 1'b0;
      for (int i = 0; i < NOSC; i++) m_osc[i] = m_shd[i];
   endtask

   task automatic pulse_soft();
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      m_led = '0; m_lock_low = '0; m_locked = 1'b1; m_fl = '0;
   endtask

   task automatic do_por();
      por_n = 1'b0; repeat (2) @(negedge clk); por_n = 1'b1;
      model_por();
   endtask

   task automatic chk_ports(input string tag);
      chk({tag, " led_out"}, {24'b0, led_out}, {24'b0, m_led});
      chk({tag, " rst_ctl_out"}, rst_ctl_out, m_rctl);
      for (int i = 0; i < NOSC; i++) chk({tag, " osc_out"}, osc_out[i*32 +: 32], m_osc[i]);
   endtask

   initial begin
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   logic [31:0] v1, v2;
   logic [7:0]  wlist [18] = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h30,
                               8'h34, 8'h38, 8'h3C, 8'h40, 8'h8C, 8'h90, 8'h94, 8'h98,
                               8'h04, 8'h24};

   initial begin
      void'($urandom(32'd20240611));
      model_por();
      repeat (3) @(negedge clk);
      por_n = 1'b1;

      // R1 reset state
      rd_chk(8'h20, "R1 lock after por");
      rd_chk(8'h8C, "R1 shadow default");
      rd_chk(8'h30, "R1 flags zero");
      chk_ports("R1");

      // R3 locked writes ignored
      do_write(8'h0C, 32'hDEAD_0001);
      do_write(8'h40, 32'h0000_0077);
      do_write(8'h90, 32'h1111_2222);
      chk_ports("R3 locked");
      rd_chk(8'h90, "R3 shadow locked");

      // R2 near-miss key keeps locked, exact key unlocks
      do_write(8'h20, 32'h0001_A05F);
      rd_chk(8'h20, "R2 near miss");
      do_write(8'h20, KEY);
      rd_chk(8'h20, "R2 unlocked");
      do_write(8'h0C, 32'hCAFE_0000);
      do_write(8'h40, 32'h0000_0003);
      chk_ports("R3 unlocked");

      // R6 reconfigure reloads from shadows
      do_write(8'h94, 32'h0BAD_F00D);
      do_write(8'h8C, 32'h1234_5678);
      pulse_reconfig();
      chk_ports("R6 reconfig");
      rd_chk(8'h94, "R6 shadow kept");

      // R2 relock with arbitrary value
      do_write(8'h20, 32'hFFFF_1234);
      rd_chk(8'h20, "R2 relock");
      do_write(8'h10, 32'h5555_5555);
      chk_ports("R3 relocked");

      // R4 flags set/clear with overlapping masks
      do_write(8'h30, 32'hF0F0_00FF);
      do_write(8'h30, 32'h0000_FF00);
      do_write(8'h34, 32'h00F0_0F0F);
      rd_chk(8'h30, "R4 set/clear");
      rd_chk(8'h34, "R11 clear alias reads zero");

      // R5 nonvolatile flags
      do_write(8'h38, 32'hA5A5_0000);
      do_write(8'h3C, 32'h0005_0000);
      rd_chk(8'h38, "R5 nv set/clear");

      // R10 switches and LEDs
      do_write(8'h08, 32'hFFFF_FF3C);
      rd_chk(8'h08, "R10 led read");
      chk_ports("R10");
      sw_in = 8'hC3;
      rd_chk(8'h04, "R10 switches");

      // R11 read-only / unmapped / misaligned writes
      do_write(8'h04, 32'hFFFF_FFFF);
      rd_chk(8'h04, "R11 write to switches");
      do_write(8'hFC, 32'h1234_0000);
      rd_chk(8'hFC, "R11 unmapped");
      do_write(8'h09, 32'h0000_0001);
      rd_chk(8'h08, "R11 misaligned write");
      rd_chk(8'h31, "R11 misaligned read");

      // R9 fast counter steps every clock
      rd_val(8'h5C, v1);
      repeat (7) @(negedge clk);
      rd_val(8'h5C, v2);
      chk("R9 fast step", v2 - v1, 32'd7);

      // R8 slow counter steps once per DIV clocks
      rd_val(8'h24, v1);
      repeat (10 * DIV) @(negedge clk);
      rd_val(8'h24, v2);
      chk("R8 slow step", v2 - v1, 32'd10);

      // R7 soft reset depth
      rd_val(8'h24, v1);
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      m_led = '0; m_lock_low = '0; m_locked = 1'b1; m_fl = '0;
      rd_val(8'h5C, v2);
      chk("R7 fast cleared", v2, 32'd0);
      rd_val(8'h24, v2);
      chk("R7 slow kept", {31'b0, (v2 - v1) <= 32'd1}, 32'd1);
      rd_chk(8'h38, "R7 nv kept");
      rd_chk(8'h30, "R7 flags cleared");
      rd_chk(8'h20, "R7 relocked");
      chk_ports("R7");

      // seeded random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom % 16);
         if (op < 6) begin
            logic [7:0] a;
            a = wlist[$urandom % 18];
            do_write(a, $urandom);
         end else if (op < 12) begin
            logic [7:0] a;
            a = 8'(($urandom % 64) * 4);
            if (a == 8'h24 || a == 8'h5C) a = 8'h20;
            if ($urandom % 8 == 0) a = a | 8'h2;
            rd_chk(a, tag_of(a));
         end else if (op == 12) begin
            pulse_reconfig();
         end else if (op == 13) begin
            pulse_soft();
         end else begin
            do_write(8'h20, ($urandom % 2 == 0) ? KEY : $urandom);
         end
         chk_ports("R3/R6 random");
      end

      // R1 power-on again clears nonvolatile flags and shadows
      do_write(8'h38, 32'h0000_00FF);
      do_por();
      rd_chk(8'h38, "R1 nv cleared by por");
      rd_chk(8'h9C, "R1 shadow default again");
      rd_val(8'h24, v1);
      chk("R1 slow counter zero", v1, 32'd0);
      chk_ports("R1 again");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule